// File: doc/BRIEF.md
# Partition Dead-Time Monitor

This block keeps per-partition statistics on how often the trigger accept was held off. A crossing strobe marks each beam-crossing slot. On every strobed cycle the block looks at each partition's inhibit flag and trigger-request flag and updates that partition's counters: inhibited crossings, inhibited active crossings, lost triggers and distributed physics triggers. An orbit strobe drives one orbit counter per partition. Partition 0 also carries a breakdown of inhibited active crossings by cause, together with counters for raw physics requests, distributed calibration and random triggers, and empty-bucket crossings. A shared event counter records every crossing on which at least one partition distributed an accept.

All counters are read through a simple registered read port. A start command clears every counter in the same cycle. The block drives two luminosity gating outputs. The run gate is controlled by a two-state run machine. The live gate is high only when no partition is inhibited. The inhibits are produced elsewhere; this block only observes them.

The run machine has two states. `RS_IDLE` is the reset state and `run_gate` is low in it. `RS_RUN` drives `run_gate` high. The transitions are:
- IDLE→RUN when `start_cmd` is seen.
- RUN→RUN when `start_cmd` is seen again; this also clears the counters again.
- RUN→IDLE when `stop_cmd` is seen without `start_cmd`.
- In every other case the machine holds its state.

Top module: `dtmon_top`

## Requirements
- R1: Apart from the orbit counters, no counter changes on a cycle where `xing_stb` is 0, whatever the other inputs are doing.
- R2: Per partition p, on a strobed crossing: counter sel 0 adds one when `part_inhibit[p]`=1, and counter sel 1 adds one when `part_inhibit[p]`=1 and `active_xing`=1.
- R3: Per partition p, counter sel 2 (lost triggers) adds one on a strobed crossing with `part_inhibit[p]`=1 and `part_req[p]`=1.
- R4: Per partition p, counter sel 3 (distributed physics) adds one on a strobed crossing with `part_req[p]`=1 and `part_inhibit[p]`=0.
- R5: Per partition p, counter sel 4 (orbits) adds one on every cycle where `orbit_stb`=1, with or without a crossing strobe.
- R6: Cause counters at global index 0..3 (bit 0 private orbit, bit 1 subdetector status, bit 2 throttling, bit 3 calibration/test cycle of `p0_cause`) add one on a strobed, active crossing with `part_inhibit[0]`=1, once for every cause bit that is set.
- R7: On a strobed crossing: global 4 adds one when `part_req[0]`=1, regardless of inhibit. Global 5 adds one when `p0_calib_trig`=1 and `part_inhibit[0]`=0. Global 6 adds one when `p0_rand_trig`=1 and `part_inhibit[0]`=0. Global 7 adds one when `active_xing`=0.
- R8: Global 8 (event number) adds one on a strobed crossing where some partition has its request set and its inhibit clear.
- R9: `start_cmd` clears every counter synchronously. A clear on the same cycle as a crossing leaves the counter at 0.
- R10: Counters are `CNT_W` bits wide (32 by default) and wrap modulo 2^`CNT_W`.
- R11: `run_gate` is 0 after reset. It is 1 from the cycle after `start_cmd`, and 0 from the cycle after `stop_cmd` without `start_cmd`. Start wins over stop.
- R12: `live_gate` is 0 in reset. Afterwards it equals the inverted OR of all `part_inhibit` bits of the previous cycle.
- R13: `rd_data` shows, one cycle later, the counter at `rd_addr`. With bit 6 = 0, the address is {partition[5:3], sel[2:0]}, and sel 5..7 read 0. With bit 6 = 1, bits [5:0] are the global index 0..8, and higher indices read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_stb | input | 1 | Crossing strobe, one cycle per crossing slot |
| active_xing | input | 1 | Crossing is filled according to the beam pattern |
| orbit_stb | input | 1 | Orbit strobe |
| start_cmd | input | 1 | Start: clear counters, enter run |
| stop_cmd | input | 1 | Stop: leave run |
| part_inhibit | input | NPART | Accept inhibited, per partition |
| part_req | input | NPART | Trigger requested, per partition |
| p0_cause | input | 4 | Partition-0 inhibit causes |
| p0_calib_trig | input | 1 | Partition-0 calibration trigger |
| p0_rand_trig | input | 1 | Partition-0 random test trigger |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | CNT_W | Read data, one cycle after address |
| run_gate | output | 1 | Running gate |
| live_gate | output | 1 | Live-time gate |

## Verification
Two functions can meet in one cycle: the synchronous clear from a start command and the counter increments of a crossing. The bench drives a start on the same cycle as a crossing in which every partition is inhibited, requesting and active, with all causes set. It then reads every address and expects zero. It also asserts start and stop together and expects the run gate to stay high.

// File: rtl/dtm_pkg.sv
package dtm_pkg;

    typedef enum logic {
        RS_IDLE = 1'b0,
        RS_RUN  = 1'b1
    } run_state_t;

    localparam int unsigned SEL_W    = 3;
    localparam int unsigned N_PSEL   = 5;
    localparam int unsigned PS_ALL   = 0;
    localparam int unsigned PS_ACT   = 1;
    localparam int unsigned PS_LOST  = 2;
    localparam int unsigned PS_PHYS  = 3;
    localparam int unsigned PS_ORBIT = 4;

    localparam int unsigned N_CAUSE  = 4;
    localparam int unsigned G_PHRAW  = 4;
    localparam int unsigned G_CALIB  = 5;
    localparam int unsigned G_RAND   = 6;
    localparam int unsigned G_EMPTY  = 7;
    localparam int unsigned G_EVENT  = 8;
    localparam int unsigned N_GLOBAL = 9;

endpackage

// File: rtl/dtm_counter.sv
module dtm_counter #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] q
);
    // Clear dominates increment; natural wrap at 2^W
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (clr) begin
            q <= '0;
        end else if (inc) begin
            q <= q + 1'b1;
        end
    end
endmodule

// File: rtl/dtm_part.sv
module dtm_part
    import dtm_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           xing,
    input  logic                           orbit,
    input  logic                           active,
    input  logic                           inhibit,
    input  logic                           req,
    output logic [N_PSEL-1:0][CNT_W-1:0]   cnt
);
    logic [N_PSEL-1:0] inc;

    always_comb begin
        inc           = '0;
        inc[PS_ALL]   = xing & inhibit;
        inc[PS_ACT]   = xing & inhibit & active;
        inc[PS_LOST]  = xing & inhibit & req;
        inc[PS_PHYS]  = xing & req & ~inhibit;
        inc[PS_ORBIT] = orbit;
    end

    for (genvar s = 0; s < N_PSEL; s++) begin : g_cnt
        dtm_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr),
            .inc   (inc[s]),
            .q     (cnt[s])
        );
    end
endmodule

// File: rtl/dtm_run_fsm.sv
module dtm_run_fsm
    import dtm_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    output logic run_gate
);
    run_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_IDLE: if (start) state_d = RS_RUN;
            RS_RUN:  if (!start && stop) state_d = RS_IDLE;
            default: state_d = RS_IDLE;
        endcase
    end

    always_comb begin
        unique case (state_q)
            RS_IDLE: run_gate = 1'b0;
            RS_RUN:  run_gate = 1'b1;
            default: run_gate = 1'b0;
        endcase
    end
endmodule

// File: rtl/dtmon_top.sv
module dtmon_top
    import dtm_pkg::*;
#(
    parameter int unsigned NPART  = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = $clog2(NPART) + SEL_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              xing_stb,
    input  logic              active_xing,
    input  logic              orbit_stb,
    input  logic              start_cmd,
    input  logic              stop_cmd,
    input  logic [NPART-1:0]  part_inhibit,
    input  logic [NPART-1:0]  part_req,
    input  logic [3:0]        p0_cause,
    input  logic              p0_calib_trig,
    input  logic              p0_rand_trig,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [CNT_W-1:0]  rd_data,
    output logic              run_gate,
    output logic              live_gate
);
    localparam int unsigned PIDX_W = $clog2(NPART);
    localparam int unsigned LOW_W  = ADDR_W - 1;

    logic [NPART-1:0][N_PSEL-1:0][CNT_W-1:0] part_cnt;
    logic [N_GLOBAL-1:0][CNT_W-1:0]          glob_cnt;
    logic [N_GLOBAL-1:0]                     g_inc;
    logic [CNT_W-1:0]                        rd_next;
    logic                                    live_q;

    // Per-partition counter sets
    for (genvar p = 0; p < NPART; p++) begin : g_part
        dtm_part #(.CNT_W(CNT_W)) u_part (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (start_cmd),
            .xing    (xing_stb),
            .orbit   (orbit_stb),
            .active  (active_xing),
            .inhibit (part_inhibit[p]),
            .req     (part_req[p]),
            .cnt     (part_cnt[p])
        );
    end

    // Partition-0 cause breakdown: every set cause is counted
    for (genvar c = 0; c < N_CAUSE; c++) begin : g_cause
        assign g_inc[c] = xing_stb & active_xing & part_inhibit[0] & p0_cause[c];
    end

    assign g_inc[G_PHRAW] = xing_stb & part_req[0];
    assign g_inc[G_CALIB] = xing_stb & p0_calib_trig & ~part_inhibit[0];
    assign g_inc[G_RAND]  = xing_stb & p0_rand_trig  & ~part_inhibit[0];
    assign g_inc[G_EMPTY] = xing_stb & ~active_xing;
    assign g_inc[G_EVENT] = xing_stb & (|(part_req & ~part_inhibit));

    for (genvar g = 0; g < N_GLOBAL; g++) begin : g_glob
        dtm_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (start_cmd),
            .inc   (g_inc[g]),
            .q     (glob_cnt[g])
        );
    end

    // Read address decode
    logic [PIDX_W-1:0] rd_pidx;
    logic [SEL_W-1:0]  rd_sel;
    logic [LOW_W-1:0]  rd_gidx;

    assign rd_pidx = rd_addr[LOW_W-1:SEL_W];
    assign rd_sel  = rd_addr[SEL_W-1:0];
    assign rd_gidx = rd_addr[LOW_W-1:0];

    always_comb begin
        rd_next = '0;
        if (!rd_addr[ADDR_W-1]) begin
            for (int p = 0; p < NPART; p++) begin
                for (int s = 0; s < N_PSEL; s++) begin
                    if (int'(rd_pidx) == p && int'(rd_sel) == s) begin
                        rd_next = part_cnt[p][s];
                    end
                end
            end
        end else begin
            for (int g = 0; g < N_GLOBAL; g++) begin
                if (int'(rd_gidx) == g) begin
                    rd_next = glob_cnt[g];
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
            live_q  <= 1'b0;
        end else begin
            rd_data <= rd_next;
            live_q  <= ~(|part_inhibit);
        end
    end

    assign live_gate = live_q;

    dtm_run_fsm u_run (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start_cmd),
        .stop     (stop_cmd),
        .run_gate (run_gate)
    );
endmodule

// File: rtl/dtm_checker.sv
module dtm_checker #(
    parameter int unsigned NPART  = 8,
    parameter int unsigned CNT_W  = 32,
    parameter int unsigned ADDR_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              xing_stb,
    input logic              orbit_stb,
    input logic              start_cmd,
    input logic              stop_cmd,
    input logic [NPART-1:0]  part_inhibit,
    input logic [ADDR_W-1:0] rd_addr,
    input logic [CNT_W-1:0]  rd_data,
    input logic              run_gate,
    input logic              live_gate
);
    AST_RUN_ENTER: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |=> run_gate); // R11

    AST_RUN_LEAVE: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_cmd && !start_cmd) |=> !run_gate); // R11

    AST_LIVE_SHUT: assert property (@(posedge clk) disable iff (!rst_n)
        (|part_inhibit) |=> !live_gate); // R12

    AST_LIVE_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
        !(|part_inhibit) |=> live_gate); // R12

    AST_CLEAR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        start_cmd |-> ##2 (rd_data == '0)); // R9

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ((rd_addr == $past(rd_addr)) && $past(!xing_stb && !orbit_stb && !start_cmd))
        |=> $stable(rd_data)); // R1
endmodule

bind dtmon_top dtm_checker #(
    .NPART  (NPART),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .xing_stb     (xing_stb),
    .orbit_stb    (orbit_stb),
    .start_cmd    (start_cmd),
    .stop_cmd     (stop_cmd),
    .part_inhibit (part_inhibit),
    .rd_addr      (rd_addr),
    .rd_data      (rd_data),
    .run_gate     (run_gate),
    .live_gate    (live_gate)
);

// File: tb/sim_dtmon_top.sv
`timescale 1ns/1ps
module sim_dtmon_top;
    localparam int NP  = 8;
    localparam int CW  = 8;
    localparam int AW  = 7;
    localparam int NV  = 12;

    // {inhibit[8], req[8], active, cause[4], calib, rand, orbit, exp_live}
    localparam logic [24:0] VEC [NV] = '{
        {8'h00, 8'h01, 1'b1, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'h01, 8'h01, 1'b1, 4'hF, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h01, 8'h00, 1'b0, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'hFF, 8'hFF, 1'b1, 4'h6, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h80, 8'hC0, 1'b1, 4'h0, 1'b1, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'hFF, 1'b0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b1},
        {8'hAA, 8'h55, 1'b1, 4'h8, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b1, 4'hF, 1'b1, 1'b0, 1'b0, 1'b1},
        {8'h0F, 8'hF0, 1'b1, 4'h1, 1'b0, 1'b0, 1'b0, 1'b0},
        {8'h01, 8'hFE, 1'b1, 4'h2, 1'b0, 1'b1, 1'b0, 1'b0},
        {8'h00, 8'h00, 1'b0, 4'h0, 1'b0, 1'b0, 1'b0, 1'b1},
        {8'hFE, 8'h01, 1'b1, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xing_stb = 1'b0, active_xing = 1'b0, orbit_stb = 1'b0;
    logic          start_cmd = 1'b0, stop_cmd = 1'b0;
    logic [NP-1:0] part_inhibit = '0, part_req = '0;
    logic [3:0]    p0_cause = '0;
    logic          p0_calib_trig = 1'b0, p0_rand_trig = 1'b0;
    logic [AW-1:0] rd_addr = '0;
    logic [CW-1:0] rd_data;
    logic          run_gate, live_gate;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;
    int mp [NP][5];
    int mg [9];

    always #2 clk = ~clk;

    dtmon_top #(.NPART(NP), .CNT_W(CW), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .xing_stb(xing_stb), .active_xing(active_xing),
        .orbit_stb(orbit_stb), .start_cmd(start_cmd), .stop_cmd(stop_cmd),
        .part_inhibit(part_inhibit), .part_req(part_req), .p0_cause(p0_cause),
        .p0_calib_trig(p0_calib_trig), .p0_rand_trig(p0_rand_trig),
        .rd_addr(rd_addr), .rd_data(rd_data), .run_gate(run_gate), .live_gate(live_gate)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_clear();
        for (int p = 0; p < NP; p++) for (int s = 0; s < 5; s++) mp[p][s] = 0;
        for (int g = 0; g < 9; g++) mg[g] = 0;
    endtask

    function automatic int exp_at(input int a);
        if (a < 64) return ((a % 8) < 5) ? (mp[a / 8][a % 8] & 8'hFF) : 0;
        return ((a - 64) < 9) ? (mg[a - 64] & 8'hFF) : 0;
    endfunction

    function automatic string tag_of(input int a);
        if (a < 64) begin
            case (a % 8)
                0, 1:    return "R2";
                2:       return "R3";
                3:       return "R4";
                4:       return "R5";
                default: return "R13";
            endcase
        end
        if (a - 64 < 4) return "R6";
        if (a - 64 < 8) return "R7";
        if (a - 64 == 8) return "R8";
        return "R13";
    endfunction

    task automatic idle_inputs();
        xing_stb = 0; active_xing = 0; orbit_stb = 0; start_cmd = 0; stop_cmd = 0;
        part_inhibit = '0; part_req = '0; p0_cause = '0; p0_calib_trig = 0; p0_rand_trig = 0;
    endtask

    task automatic read_all(input string ctx);
        for (int a = 0; a < 128; a++) begin
            rd_addr = a[AW-1:0];
            @(negedge clk);
            chk($sformatf("%s %s addr=%0d", ctx, tag_of(a), a), int'(rd_data), exp_at(a));
        end
    endtask

    task automatic crossing(input logic [24:0] v, input bit with_start);
        logic [7:0] inh, req;
        logic act, cal, rnd, orb;
        logic [3:0] cs;
        {inh, req, act, cs, cal, rnd, orb} = v[24:1];
        part_inhibit = inh; part_req = req; active_xing = act; p0_cause = cs;
        p0_calib_trig = cal; p0_rand_trig = rnd; orbit_stb = orb;
        xing_stb = 1; start_cmd = with_start;
        if (with_start) model_clear();
        else begin
            for (int p = 0; p < NP; p++) begin
                if (inh[p]) mp[p][0]++;
                if (inh[p] && act) mp[p][1]++;
                if (inh[p] && req[p]) mp[p][2]++;
                if (req[p] && !inh[p]) mp[p][3]++;
                if (orb) mp[p][4]++;
            end
            for (int c = 0; c < 4; c++) if (act && inh[0] && cs[c]) mg[c]++;
            if (req[0]) mg[4]++;
            if (cal && !inh[0]) mg[5]++;
            if (rnd && !inh[0]) mg[6]++;
            if (!act) mg[7]++;
            if ((req & ~inh) != 0) mg[8]++;
        end
        @(negedge clk);
        idle_inputs();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        model_clear();
        repeat (3) @(negedge clk);
        // Reset state
        chk("R11 reset run_gate", int'(run_gate), 0);
        chk("R12 reset live_gate", int'(live_gate), 0);
        chk("R13 reset rd_data", int'(rd_data), 0);
        rst_n = 1;
        @(negedge clk);
        chk("R12 idle live_gate", int'(live_gate), 1);

        // Table walk: each vector is one crossing; live gate checked after it
        for (int i = 0; i < NV; i++) begin
            crossing(VEC[i], 1'b0);
            chk($sformatf("R12 vec%0d live_gate", i), int'(live_gate), int'(VEC[i][0]));
        end
        read_all("table");

        // R1: busy inputs without crossing strobe change nothing
        part_inhibit = '1; part_req = '1; active_xing = 1; p0_cause = '1;
        p0_calib_trig = 1; p0_rand_trig = 1;
        repeat (4) @(negedge clk);
        idle_inputs();
        @(negedge clk);
        read_all("R1 no-strobe");

        // R5/R10: orbit-only strobes, wrap past 2^CW
        orbit_stb = 1;
        repeat (259) @(negedge clk);
        orbit_stb = 0;
        for (int p = 0; p < NP; p++) mp[p][4] += 259;
        for (int p = 0; p < NP; p++) begin
            rd_addr = AW'(p * 8 + 4);
            @(negedge clk);
            chk($sformatf("R10 wrap orbit p%0d", p), int'(rd_data), mp[p][4] & 8'hFF);
        end

        // R9: start coinciding with a fully loaded crossing
        crossing({8'hFF, 8'hFF, 1'b1, 4'hF, 1'b1, 1'b1, 1'b1, 1'b0}, 1'b1);
        chk("R11 start run_gate", int'(run_gate), 1);
        read_all("R9 clear");

        // R11: stop, then start together with stop
        stop_cmd = 1;
        @(negedge clk);
        stop_cmd = 0;
        chk("R11 stop run_gate", int'(run_gate), 0);
        start_cmd = 1; stop_cmd = 1;
        @(negedge clk);
        start_cmd = 0; stop_cmd = 0;
        chk("R11 start beats stop", int'(run_gate), 1);
        @(negedge clk);
        chk("R11 run holds", int'(run_gate), 1);

        // Second pattern after clear
        crossing(VEC[3], 1'b0);
        crossing(VEC[5], 1'b0);
        read_all("post-clear");

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule